// File: doc/BRIEF.md
# Buffered Output-Compare Channel

This block is one output-compare channel that watches a free-running time counter. Software writes a compare value and selects an output mode in a small control register. When the counter reaches the compare value the channel records an event flag, can request an interrupt, and drives an output pin. Depending on the mode, the pin toggles or emits a single-cycle high pulse.

The compare register has two stages: an active value and a one-entry buffer. The first value is loaded into the active stage while the channel is disabled (mode zero). Once the channel is armed, further writes land in the buffer. On each match the buffered value is promoted to the active stage, so software can always keep the next edge queued one period ahead. A periodic output such as a one-pulse-per-second signal can therefore run with no gaps. Only the low `CW` bits of the counter and of the compare values take part in the comparison.

Top module: `oc_compare_chan`

## Requirements
- R1: After reset the control readback is 0, the active compare value is 0, and both the pin and the interrupt output are low.
- R2: In the control register the mode field sits at bits [5:2] and the interrupt enable at bit 6. Bit 7 reads back the event flag, and bits [1:0] always read 0. A control write updates the mode and the enable from the written data.
- R3: Writing a control word with bit 7 set clears the event flag, and writing one with bit 7 clear leaves it unchanged. If a match occurs in the same cycle as the clearing write, the flag stays set.
- R4: The interrupt output is high exactly while both the event flag and the interrupt enable are set.
- R5: A compare write while the mode is 0 loads the active compare value directly, visible on the compare readback one cycle later, and empties the buffer.
- R6: A compare write while the mode is nonzero goes to the buffer and does not change the active compare value.
- R7: On a match with the buffer full, the buffered value becomes the active value and the buffer empties. With the buffer empty the active value is kept, and the channel matches again the next time the counter reaches it.
- R8: No match is reported while the mode is 0: the flag is not set and the pin does not respond.
- R9: Only the low CW bits of a compare write are stored and compared. Higher written bits are ignored.
- R10: In mode 0x5 the pin inverts on the clock edge that ends each match cycle.
- R11: In mode 0xF the pin is high for exactly one cycle after each match and low otherwise.
- R12: Writing 0 to the control register disables the channel. The interrupt drops at once, the pin goes low one cycle later, and no later equality produces a match.
- R13: A match is reported once when the counter first equals the active value. A counter that holds that value for more cycles produces no further match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | CW | Current time-counter value |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback: flag, enable, mode |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | DW | Compare write data |
| cmp_rdata | output | DW | Active compare value, zero-extended |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CW = 12 and DW = 16. The bus is then four bits wider than the compared field, so writes with high bits set show directly whether those bits are discarded. Because the counter is only 12 bits wide, the bench can drive every compare point as a literal counter value. It also reaches the promotion sequence with a full buffer, a rematch with an empty buffer, the same-cycle clear-versus-set race, and a counter held on the compare value, all within a few hundred cycles.

// File: rtl/oc_chan_pkg.sv
package oc_chan_pkg;
  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  localparam int CTL_W       = 8;
  localparam int BIT_MODE_LO = 2;
  localparam int BIT_IE      = 6;
  localparam int BIT_FLAG    = 7;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [3:0] mode;
  } ctl_t;

  // Next pin value for a given mode, present pin level and match pulse.
  function automatic logic next_pin(input logic [3:0] mode, input logic pin,
                                    input logic hit);
    case (mode)
      MODE_OFF:    return 1'b0;
      MODE_TOGGLE: return pin ^ hit;
      MODE_PULSE:  return hit;
      default:     return pin;
    endcase
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input ctl_t c);
    return {c.flag, c.ie, c.mode, 2'b00};
  endfunction
endpackage

// File: rtl/oc_ctl_reg.sv
module oc_ctl_reg
  import oc_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             match,
  output ctl_t             ctl
);
  logic clr_req;
  assign clr_req = wr && wdata[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr) begin
        ctl.mode <= wdata[BIT_MODE_LO +: 4];
        ctl.ie   <= wdata[BIT_IE];
      end
      if (match)        ctl.flag <= 1'b1;
      else if (clr_req) ctl.flag <= 1'b0;
    end
  end

  // R3: the flag only rises on the edge that ends a match cycle
  p_flag_from_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.flag) |-> $past(match));
  // R3: a clearing write with no match leaves the flag low
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match) |=> !ctl.flag);
endmodule

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int CW = 31,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          armed,
  input  logic          match,
  output logic [CW-1:0] act,
  output logic          buf_full
);
  logic [CW-1:0] nxt;
  logic          load_act, load_buf;

  assign load_act = wr && !armed;
  assign load_buf = wr && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= '0;
      nxt      <= '0;
      buf_full <= 1'b0;
    end else begin
      if (load_act) begin
        act      <= wdata[CW-1:0];
        buf_full <= 1'b0;
      end else begin
        if (match && buf_full) act <= nxt;
        if (load_buf) begin
          nxt      <= wdata[CW-1:0];
          buf_full <= 1'b1;
        end else if (match) begin
          buf_full <= 1'b0;
        end
      end
    end
  end

  // R7: a match with a queued value promotes it
  p_promote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && buf_full && !wr) |=> (act == $past(nxt)) && !buf_full);
  // R6: an armed write never disturbs the active value without a match
  p_armed_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_buf && !match) |=> $stable(act));
  // R5: a disarmed write lands in the active stage
  p_direct_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> (act == $past(wdata[CW-1:0])) && !buf_full);
endmodule

// File: rtl/oc_match_pin.sv
module oc_match_pin
  import oc_chan_pkg::*;
#(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] act,
  input  logic [3:0]    mode,
  output logic          match,
  output logic          pin
);
  logic eq, eq_q;

  assign eq    = (mode != MODE_OFF) && (cnt == act);
  assign match = eq && !eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q <= 1'b0;
      pin  <= 1'b0;
    end else begin
      eq_q <= eq;
      pin  <= next_pin(mode, pin, match);
    end
  end

  // R10: toggle mode inverts the pin on each match
  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOGGLE && match) |=> pin != $past(pin));
  // R11: pulse mode gives one high cycle
  p_pulse_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && match) |=> pin);
  p_pulse_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && !match) |=> !pin);
  // R13: a counter parked on the compare value does not match twice
  p_single_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> ($stable(cnt) |-> !match));
  // R8: no match while disabled
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !match);
endmodule

// File: rtl/oc_compare_chan.sv
module oc_compare_chan
  import oc_chan_pkg::*;
#(
  parameter int CW = 31,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt_in,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cmp_wr,
  input  logic [DW-1:0]    cmp_wdata,
  output logic [DW-1:0]    cmp_rdata,
  output logic             pin_out,
  output logic             irq
);
  ctl_t          ctl;
  logic          match;
  logic [CW-1:0] act;
  logic          buf_full;
  logic          armed;

  assign armed = (ctl.mode != MODE_OFF);

  oc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .match(match), .ctl(ctl)
  );

  oc_cmp_store #(.CW(CW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
    .armed(armed), .match(match), .act(act), .buf_full(buf_full)
  );

  oc_match_pin #(.CW(CW)) u_hit (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_in), .act(act), .mode(ctl.mode),
    .match(match), .pin(pin_out)
  );

  assign ctl_rdata = pack_ctl(ctl);
  assign cmp_rdata = DW'(act);
  assign irq       = ctl.flag & ctl.ie;

  // R12: disabling write drops the pin within one further cycle
  p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == '0) |=> ##1 !pin_out);
endmodule

// File: tb/oc_compare_chan_test.sv
module oc_compare_chan_test;
  localparam int CW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic          ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic          cmp_wr = 1'b0;
  logic [DW-1:0] cmp_wdata = '0;
  logic [DW-1:0] cmp_rdata;
  logic          pin_out, irq;

  always #2.5 clk = ~clk;

  oc_compare_chan #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata), .pin_out(pin_out), .irq(irq)
  );

  typedef struct {
    string       req;
    int          sel;   // 0 ctl readback, 1 compare readback, 2 pin, 3 irq
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  event  ev_cmp;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Monitor: pops expected items and compares them with the outputs
  initial forever begin
    @(ev_cmp);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = {8'h00, ctl_rdata};
        1: act = cmp_rdata;
        2: act = {15'd0, pin_out};
        default: act = {15'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string req, input int sel, input logic [15:0] e);
    item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask

  task automatic flush();
    -> ev_cmp;
    #0.5;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [DW-1:0] d);
    cmp_wr = 1'b1; cmp_wdata = d;
    tick();
    cmp_wr = 1'b0;
  endtask

  task automatic set_cnt(input logic [CW-1:0] v);
    cnt_in = v;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_v("R1 ctl", 0, 16'h00); expect_v("R1 cmp", 1, 16'h0000);
    expect_v("R1 pin", 2, 0);      expect_v("R1 irq", 3, 0);
    flush();

    // R5 R9: disarmed write loads active, high bits dropped
    wr_cmp(16'hF064);
    expect_v("R5 R9 direct load", 1, 16'h0064); flush();

    // R8: equality while disabled does nothing
    set_cnt(12'h064);
    expect_v("R8 no flag", 0, 16'h00); expect_v("R8 pin", 2, 0); flush();
    set_cnt(12'h000);

    // R2: fields, low bits read zero
    wr_ctl(8'h57);
    expect_v("R2 readback", 0, 16'h54); flush();

    // R6: armed write buffers
    wr_cmp(16'h00C8);
    expect_v("R6 active kept", 1, 16'h0064); flush();

    set_cnt(12'h063);
    expect_v("R6 no early hit", 0, 16'h54); flush();
    set_cnt(12'h064);
    expect_v("R10 toggle high", 2, 1); expect_v("R4 irq on", 3, 1);
    expect_v("R7 promoted", 1, 16'h00C8); expect_v("R3 flag set", 0, 16'hD4);
    flush();

    // R3 clear, R4 irq drops
    wr_ctl(8'hD4);
    expect_v("R3 cleared", 0, 16'h54); expect_v("R4 irq off", 3, 0); flush();

    // R7: empty buffer keeps active value
    set_cnt(12'h0C8);
    expect_v("R10 toggle low", 2, 0); expect_v("R7 active kept", 1, 16'h00C8);
    flush();
    tick();
    expect_v("R13 held counter", 2, 0); flush();
    set_cnt(12'h0C9);
    set_cnt(12'h0C8);
    expect_v("R7 rematch", 2, 1); flush();

    // R3 bit7 clear leaves flag; R4 enable off
    wr_ctl(8'h54);
    expect_v("R3 flag kept", 0, 16'hD4); flush();
    wr_ctl(8'h14);
    expect_v("R4 ie off", 3, 0); expect_v("R4 flag still", 0, 16'h94); flush();

    // R3: set wins over same-cycle clear
    set_cnt(12'h000);
    cnt_in = 12'h0C8; ctl_wr = 1'b1; ctl_wdata = 8'h94;
    tick();
    ctl_wr = 1'b0;
    expect_v("R3 set wins", 0, 16'h94); expect_v("R10 toggle", 2, 0); flush();

    // R11: pulse mode
    wr_ctl(8'h80);
    expect_v("R12 disabled", 0, 16'h00); flush();
    wr_cmp(16'h0200);
    set_cnt(12'h1FF);
    wr_ctl(8'h3C);
    set_cnt(12'h200);
    expect_v("R11 pulse high", 2, 1); expect_v("R11 flag", 0, 16'hBC); flush();
    tick();
    expect_v("R11 pulse one cycle", 2, 0); flush();

    // R9: high bits of a write ignored in the comparison
    wr_ctl(8'h80);
    wr_cmp(16'hF300);
    expect_v("R9 masked", 1, 16'h0300); flush();
    set_cnt(12'h000);
    wr_ctl(8'h14);
    set_cnt(12'h300);
    expect_v("R9 hit on low bits", 0, 16'h94); expect_v("R9 pin", 2, 1); flush();

    // R12: disable
    wr_ctl(8'h00);
    expect_v("R12 irq", 3, 0); expect_v("R12 ctl", 0, 16'h80); flush();
    tick();
    expect_v("R12 pin low", 2, 0); flush();
    wr_ctl(8'h80);
    set_cnt(12'h000);
    set_cnt(12'h300);
    expect_v("R12 no match", 0, 16'h00); expect_v("R12 pin stays", 2, 0); flush();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule